// File: doc/BRIEF.md
# Safety Error Signaling Aggregator

The aggregator collects a parameterized number of safety error event lines (up to 1024) into one place. Each line gets its own configuration: an enable, a priority class (low or high) and a detection type (level-sensitive or edge-triggered pulse). A status bit per event records the event. The enabled pending events of each priority class are ORed onto a low-priority or a high-priority interrupt line. High-priority enabled events also drive an external error pin. Once that pin has been raised, it stays asserted for a programmable minimum number of clock cycles.

Software reaches the block through a flat register port with a combinational read path. It can inject events, force the error pin, and clear status bits by writing ones. The safety-critical configuration (event enables, priority map and pin hold time) is stored twice. Any difference between the two copies is reported as an internal high-priority error. A diagnostic control bit lets writes skip the second copy, so that this comparison path can be exercised.

Top module: `err_signal_agg`

## Requirements
- R1: After reset, all enable, priority, type, status and control fields read 0, the hold field reads 4, and `loInt`, `hiInt` and `errPin` are low.
- R2: The register address is {field[2:0], word[4:0]}. Fields: 0 enable, 1 priority (1 = high), 2 type (1 = pulse), 3 status, 4 force, 5 hold time (word 0, bits [HOLD_W-1:0]), 6 control (word 0). Event i sits in bit i%32 of word i/32. Bits for events that do not exist read 0.
- R3: Level-type events have type bit 0. For such an event, status is set in every cycle the input is sampled high. A clear written while the input is high has no effect. Status stays set after the input falls.
- R4: Pulse-type events have type bit 1. For such an event, status is set only when the input is sampled high after being sampled low in the previous cycle. A clear takes effect even while the input stays high.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R6: `loInt` is high while any enabled, pending, low-priority event exists. `hiInt` is high while any enabled, pending, high-priority event exists or a redundancy mismatch is present. Both lines follow the status in the same cycle.
- R7: A disabled event still records status but raises neither interrupt nor the error pin.
- R8: `errPin` rises one cycle after any cycle in which `hiInt` or the control force-pin bit is high. After the last such cycle, the pin stays high for max(hold,1) cycles in total, even if the status is cleared earlier.
- R9: Writing 1 to a force bit sets that event's status. The force field always reads 0.
- R10: Control bit 0 forces the error-pin condition while it is set.
- R11: Enable, priority and hold are kept in two copies. While control bit 1 is set, writes update only the primary copy. Control bit 2 reads 1 whenever the copies differ. A mismatch raises `hiInt` and the error pin. Readback returns the primary copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evIn | input | NUM_EVENTS | Error event lines |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address {field, word} |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| loInt | output | 1 | Low-priority interrupt |
| hiInt | output | 1 | High-priority interrupt |
| errPin | output | 1 | Severe-error output pin |

## Verification
An event sampled at a clock edge shows up in status, and therefore in `loInt` and `hiInt`, right after that edge. `errPin` follows one edge later. A register write is visible on the combinational read port in the cycle after its write edge. The scoreboard tags every expected item with the cycle in which it is due. The monitor compares it at the falling edge of that cycle. The pin-hold checks count edges one by one from the clearing write, so that the exact cycle the pin drops is checked.

// File: rtl/err_agg_pkg.sv
package err_agg_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    FLD_EN    = 3'd0,
    FLD_PRIO  = 3'd1,
    FLD_TYPE  = 3'd2,
    FLD_STAT  = 3'd3,
    FLD_FORCE = 3'd4,
    FLD_HOLD  = 3'd5,
    FLD_CTRL  = 3'd6,
    FLD_NONE  = 3'd7
  } fieldE;

  typedef struct packed {
    logic              wrEn;
    logic              wrPrio;
    logic              wrType;
    logic              wrClr;
    logic              wrForce;
    logic              wrHold;
    logic              wrCtrl;
    logic [4:0]        word;
    logic [WORD_W-1:0] data;
  } regStrobeT;
endpackage

// File: rtl/err_agg_ctrl.sv
module err_agg_ctrl
  import err_agg_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output regStrobeT         strobe,
  output fieldE             rdField,
  output logic [4:0]        rdWord
);
  fieldE fieldSel;

  assign fieldSel = fieldE'(regAddr[7:5]);
  assign rdField  = fieldSel;
  assign rdWord   = regAddr[4:0];

  always_comb begin
    strobe         = '0;
    strobe.word    = regAddr[4:0];
    strobe.data    = regWdata;
    strobe.wrEn    = regWe && fieldSel == FLD_EN;
    strobe.wrPrio  = regWe && fieldSel == FLD_PRIO;
    strobe.wrType  = regWe && fieldSel == FLD_TYPE;
    strobe.wrClr   = regWe && fieldSel == FLD_STAT;
    strobe.wrForce = regWe && fieldSel == FLD_FORCE;
    strobe.wrHold  = regWe && fieldSel == FLD_HOLD && regAddr[4:0] == 5'd0;
    strobe.wrCtrl  = regWe && fieldSel == FLD_CTRL && regAddr[4:0] == 5'd0;
  end
endmodule

// File: rtl/err_agg_dp.sv
module err_agg_dp
  import err_agg_pkg::*;
#(
  parameter int NUM_EVENTS = 40,
  parameter int HOLD_W     = 16,
  parameter int HOLD_RST   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evIn,
  input  regStrobeT             strobe,
  input  fieldE                 rdField,
  input  logic [4:0]            rdWord,
  output logic [WORD_W-1:0]     rdData,
  output logic                  loInt,
  output logic                  hiInt,
  output logic                  errPin
);
  localparam int NUM_WORDS = (NUM_EVENTS + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;

  logic [NUM_EVENTS-1:0] enPri, enCpy, prPri, prCpy, evType, evStat, inPrev;
  logic [NUM_EVENTS-1:0] wordHit, wrBits, setVec, clrVec, frcVec, active;
  logic [HOLD_W-1:0]     holdPri, holdCpy, pinCnt;
  logic                  forcePin, skipCpy, mismatch, pinCond;

  for (genvar i = 0; i < NUM_EVENTS; i++) begin : g_map
    assign wordHit[i] = strobe.word == 5'(i / WORD_W);
    assign wrBits[i]  = wordHit[i] & strobe.data[i % WORD_W];
  end

  assign setVec = evIn & ~(evType & inPrev);
  assign clrVec = strobe.wrClr   ? wrBits : '0;
  assign frcVec = strobe.wrForce ? wrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPri <= '0; enCpy <= '0; prPri <= '0; prCpy <= '0;
      evType <= '0; evStat <= '0; inPrev <= '0;
      holdPri <= HOLD_W'(HOLD_RST); holdCpy <= HOLD_W'(HOLD_RST);
      forcePin <= 1'b0; skipCpy <= 1'b0;
    end else begin
      inPrev <= evIn;
      evStat <= (evStat & ~clrVec) | setVec | frcVec;
      if (strobe.wrEn) begin
        enPri <= (enPri & ~wordHit) | wrBits;
        if (!skipCpy) enCpy <= (enCpy & ~wordHit) | wrBits;
      end
      if (strobe.wrPrio) begin
        prPri <= (prPri & ~wordHit) | wrBits;
        if (!skipCpy) prCpy <= (prCpy & ~wordHit) | wrBits;
      end
      if (strobe.wrType) evType <= (evType & ~wordHit) | wrBits;
      if (strobe.wrHold) begin
        holdPri <= strobe.data[HOLD_W-1:0];
        if (!skipCpy) holdCpy <= strobe.data[HOLD_W-1:0];
      end
      if (strobe.wrCtrl) begin
        forcePin <= strobe.data[0];
        skipCpy  <= strobe.data[1];
      end
    end
  end

  assign mismatch = (enPri != enCpy) || (prPri != prCpy) || (holdPri != holdCpy);
  assign active   = evStat & enPri;
  assign loInt    = |(active & ~prPri);
  assign hiInt    = (|(active & prPri)) | mismatch;
  assign pinCond  = hiInt | forcePin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPin <= 1'b0;
      pinCnt <= '0;
    end else if (pinCond) begin
      errPin <= 1'b1;
      pinCnt <= holdPri;
    end else if (pinCnt > HOLD_W'(1)) begin
      errPin <= 1'b1;
      pinCnt <= pinCnt - HOLD_W'(1);
    end else begin
      errPin <= 1'b0;
      pinCnt <= '0;
    end
  end

  logic [PAD_W-1:0] padEn, padPr, padTy, padSt;
  assign padEn = PAD_W'(enPri);
  assign padPr = PAD_W'(prPri);
  assign padTy = PAD_W'(evType);
  assign padSt = PAD_W'(evStat);

  always_comb begin
    rdData = '0;
    if (int'(rdWord) < NUM_WORDS) begin
      unique case (rdField)
        FLD_EN:   rdData = padEn[int'(rdWord) * WORD_W +: WORD_W];
        FLD_PRIO: rdData = padPr[int'(rdWord) * WORD_W +: WORD_W];
        FLD_TYPE: rdData = padTy[int'(rdWord) * WORD_W +: WORD_W];
        FLD_STAT: rdData = padSt[int'(rdWord) * WORD_W +: WORD_W];
        FLD_HOLD: if (rdWord == 5'd0) rdData = WORD_W'(holdPri);
        FLD_CTRL: if (rdWord == 5'd0) rdData = {29'd0, mismatch, skipCpy, forcePin};
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/err_signal_agg.sv
module err_signal_agg
  import err_agg_pkg::*;
#(
  parameter int NUM_EVENTS = 40,
  parameter int HOLD_W     = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evIn,
  input  logic                  regWe,
  input  logic [7:0]            regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  output logic                  loInt,
  output logic                  hiInt,
  output logic                  errPin
);
  regStrobeT  strobe;
  fieldE      rdField;
  logic [4:0] rdWord;

  err_agg_ctrl ctrl_i (
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .strobe(strobe), .rdField(rdField), .rdWord(rdWord)
  );

  err_agg_dp #(.NUM_EVENTS(NUM_EVENTS), .HOLD_W(HOLD_W)) dp_i (
    .clk(clk), .rstN(rstN), .evIn(evIn), .strobe(strobe),
    .rdField(rdField), .rdWord(rdWord), .rdData(regRdata),
    .loInt(loInt), .hiInt(hiInt), .errPin(errPin)
  );
endmodule

// File: rtl/err_signal_agg_chk.sv
module err_signal_agg_chk #(
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hiInt,
  input logic              errPin,
  input logic              mismatch,
  input logic [HOLD_W-1:0] holdVal
);
  // R11: a copy mismatch always reaches the high-priority interrupt
  assert_mismatch_hi_R11: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> hiInt);

  // R8: high-priority condition raises the pin on the next edge
  assert_hi_to_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    hiInt |=> errPin);

  // R8: pin never drops right after a cycle with the condition present
  assert_no_early_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errPin) |-> !$past(hiInt));

  // R8: with hold of two or more the pin lasts beyond its first cycle
  assert_min_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(errPin) && $past(holdVal) >= HOLD_W'(2)) |=> errPin);
endmodule

bind err_signal_agg err_signal_agg_chk #(.HOLD_W(HOLD_W)) chk_i (
  .clk(clk), .rstN(rstN), .hiInt(hiInt), .errPin(errPin),
  .mismatch(dp_i.mismatch), .holdVal(dp_i.holdPri)
);

// File: tb/err_signal_agg_tb_top.sv
module err_signal_agg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;
  localparam logic [2:0] F_EN = 3'd0, F_PRIO = 3'd1, F_TYPE = 3'd2,
    F_STAT = 3'd3, F_FORCE = 3'd4, F_HOLD = 3'd5, F_CTRL = 3'd6;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [N-1:0] evIn = '0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic loInt, hiInt, errPin;

  err_signal_agg #(.NUM_EVENTS(N)) dut_i (
    .clk(clk), .rstN(rstN), .evIn(evIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .loInt(loInt), .hiInt(hiInt),
    .errPin(errPin)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct { int sel; logic [31:0] exp; string tag; int due; } itemT;
  itemT sbq[$];
  int cycle = 0, checks = 0, failures = 0;
  bit finished = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  // monitor: compare every item due in the current cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cycle) begin
      itemT it;
      logic [31:0] act;
      it = sbq.pop_front();
      case (it.sel)
        0: act = regRdata;
        1: act = 32'(errPin);
        2: act = 32'(hiInt);
        default: act = 32'(loInt);
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expectOut(int sel, logic [2:0] f, logic [4:0] w, logic [31:0] exp, string tag);
    itemT it;
    if (sel == 0) regAddr = {f, w};
    it.sel = sel; it.exp = exp; it.tag = tag; it.due = cycle;
    sbq.push_back(it);
  endtask

  task automatic expRd(logic [2:0] f, logic [4:0] w, logic [31:0] exp, string tag);
    expectOut(0, f, w, exp, tag);
  endtask

  task automatic wr(logic [2:0] f, logic [4:0] w, logic [31:0] d);
    regWe = 1'b1; regAddr = {f, w}; regWdata = d;
    tick();
    regWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expRd(F_EN, 0, 0, "R1 enable"); expectOut(1, 0, 0, 0, "R1 pin");
    expectOut(2, 0, 0, 0, "R1 hiInt"); expectOut(3, 0, 0, 0, "R1 loInt"); tick();
    expRd(F_HOLD, 0, 4, "R1 hold"); tick();
    expRd(F_CTRL, 0, 0, "R1 ctrl"); tick();
    expRd(F_STAT, 1, 0, "R1 status"); tick();

    // R2 configuration and readback
    wr(F_EN, 0, 32'hF); wr(F_EN, 1, 32'hFFFF_FFFF);
    wr(F_PRIO, 0, 32'h3); wr(F_TYPE, 0, 32'h5); wr(F_HOLD, 0, 3);
    expRd(F_EN, 1, 32'hFF, "R2 enable word1 padding"); tick();
    expRd(F_TYPE, 0, 32'h5, "R2 type"); tick();
    expRd(F_HOLD, 0, 3, "R2 hold"); tick();

    // R4/R6 pulse low-priority event 2
    evIn[2] = 1'b1; tick(); evIn[2] = 1'b0;
    expRd(F_STAT, 0, 32'h4, "R4 pulse sets status");
    expectOut(3, 0, 0, 1, "R6 loInt"); expectOut(2, 0, 0, 0, "R6 hiInt"); tick();
    expectOut(1, 0, 0, 0, "R6 low prio no pin"); tick();
    wr(F_STAT, 0, 32'h4);
    expRd(F_STAT, 0, 0, "R5 clear"); expectOut(3, 0, 0, 0, "R5 loInt off"); tick();

    // R3 level event 3
    evIn[3] = 1'b1; tick();
    expRd(F_STAT, 0, 32'h8, "R3 level set"); tick();
    wr(F_STAT, 0, 32'h8);
    expRd(F_STAT, 0, 32'h8, "R3 clear blocked while high"); tick();
    evIn[3] = 1'b0; tick();
    expRd(F_STAT, 0, 32'h8, "R3 sticky after fall"); tick();
    wr(F_STAT, 0, 32'h8);
    expRd(F_STAT, 0, 0, "R5 level clear"); tick();

    // R4 pulse event 0 held high
    evIn[0] = 1'b1; tick();
    expRd(F_STAT, 0, 32'h1, "R4 edge set"); expectOut(2, 0, 0, 1, "R6 hiInt"); tick();
    wr(F_STAT, 0, 32'h1);
    expRd(F_STAT, 0, 0, "R4 clear while held"); tick();
    expRd(F_STAT, 0, 0, "R4 no reset while held"); tick();
    evIn[0] = 1'b0;
    repeat (5) tick();
    expectOut(1, 0, 0, 0, "R8 pin released"); tick();

    // R8 hold time 3 with early clear (level event 1)
    evIn[1] = 1'b1; tick();
    expectOut(2, 0, 0, 1, "R8 hiInt"); expectOut(1, 0, 0, 0, "R8 pin not yet");
    evIn[1] = 1'b0; wr(F_STAT, 0, 32'h2);
    expectOut(1, 0, 0, 1, "R8 pin cycle1"); expectOut(2, 0, 0, 0, "R8 hiInt cleared"); tick();
    expectOut(1, 0, 0, 1, "R8 pin cycle2"); tick();
    expectOut(1, 0, 0, 1, "R8 pin cycle3"); tick();
    expectOut(1, 0, 0, 0, "R8 pin drops"); tick();

    // R7 disabled event 4
    evIn[4] = 1'b1; tick();
    expRd(F_STAT, 0, 32'h10, "R7 status recorded");
    expectOut(2, 0, 0, 0, "R7 no hiInt"); expectOut(3, 0, 0, 0, "R7 no loInt"); tick();
    expectOut(1, 0, 0, 0, "R7 no pin");
    evIn[4] = 1'b0; wr(F_STAT, 0, 32'h10);
    expRd(F_STAT, 0, 0, "R7 cleared"); tick();

    // R9 force event 35
    wr(F_FORCE, 1, 32'h8);
    expRd(F_STAT, 1, 32'h8, "R9 forced status"); expectOut(3, 0, 0, 1, "R9 loInt"); tick();
    expRd(F_FORCE, 1, 0, "R9 force reads 0"); tick();
    wr(F_STAT, 1, 32'h8);
    expRd(F_STAT, 1, 0, "R9 cleared"); expectOut(3, 0, 0, 0, "R9 loInt off"); tick();

    // R10 force pin
    wr(F_CTRL, 0, 32'h1);
    expRd(F_CTRL, 0, 32'h1, "R10 ctrl"); expectOut(1, 0, 0, 0, "R10 pin delay"); tick();
    expectOut(1, 0, 0, 1, "R10 pin forced"); tick();
    wr(F_CTRL, 0, 0);
    repeat (4) tick();
    expectOut(1, 0, 0, 0, "R10 pin released"); tick();

    // R11 redundancy mismatch
    wr(F_CTRL, 0, 32'h2); wr(F_EN, 0, 32'h1F);
    expRd(F_CTRL, 0, 32'h6, "R11 mismatch flag"); expectOut(2, 0, 0, 1, "R11 hiInt"); tick();
    expectOut(1, 0, 0, 1, "R11 pin"); expRd(F_EN, 0, 32'h1F, "R11 primary readback"); tick();
    wr(F_CTRL, 0, 0); wr(F_EN, 0, 32'h1F);
    expRd(F_CTRL, 0, 0, "R11 mismatch gone"); expectOut(2, 0, 0, 0, "R11 hiInt off"); tick();
    repeat (4) tick();
    expectOut(1, 0, 0, 0, "R11 pin released"); tick();

    tick();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule